// File: doc/BRIEF.md
# Interrupt Mask and Status Bank

This block gathers 64 already-conditioned interrupt lines and presents them to three independent parent outputs. Each output has its own bank, which holds a 64-bit enable mask and a 64-bit set of software-forced pending bits. The 64 lines are handled as two 32-bit halves, and each half has its own register group inside the bank. Software reads a masked view and a raw view of each half. It changes the enable mask and the soft bits only through write-one-to-set and write-one-to-clear ports, so no read-modify-write sequence is needed and nothing can race between two writers.

A bank's raw state is the conditioned input ORed with its soft bits. The masked state is the raw state ANDed with the enable mask. Each bank drives one registered interrupt output, which is high when any masked bit of that bank is set. A service routine reads the masked word of the low half, then that of the high half, and handles the set bits from the lowest index upward. Edge and level conditioning, priority encoding and vectoring happen outside this block.

Top module: `irq_mask_bank_top`

## Requirements
- R1: While `rst_ni` is low and just after it rises, all enable and soft bits are zero, `irq_o` is 0, `bus_rvalid_o` is 0 and `bus_rdata_o` is 0.
- R2: Reading offset 0x04 of a group returns that half's raw state: the conditioned input bits ORed with the bank's soft bits.
- R3: Reading offset 0x00 of a group returns that half's masked state: the raw state ANDed with the bank's enable mask.
- R4: A write to offset 0x08 (enable set) sets the enable bits at the positions where the write data is 1. All other enable bits keep their value.
- R5: A write to offset 0x0C (enable clear) clears the enable bits at the positions where the write data is 1. All other enable bits keep their value. Writing all ones disables the whole half.
- R6: Writes to offsets 0x10 (soft set) and 0x14 (soft clear) set and clear the soft bits at the positions where the write data is 1. All other soft bits keep their value.
- R7: Lines 0 to 31 use the group at bank offset 0x00. Lines 32 to 63 use the group at bank offset 0x18, where line 32 is bit 0. A write to one half never changes the other half.
- R8: The three banks sit at bus address bases 0x000, 0x100 and 0x300, and bits [9:8] of the address select the bank. Each bank keeps its own enable and soft state and drives only its own bit of `irq_o`: bank 0 drives bit 0, bank 1 drives bit 1 and bank 2 drives bit 2.
- R9: `irq_o[b]` equals the OR of all 64 masked bits of bank b as they stood one clock earlier.
- R10: Writes to the masked-status and raw-status offsets change no state.
- R11: A read returns zero when the address falls in any of these places: page 0x200, a bank offset of 0x30 or above, an address that is not a multiple of 4, or one of the write-only set and clear offsets. Writes to unmapped addresses change no state.
- R12: A read strobe at one clock edge produces `bus_rvalid_o` high with the read data after that edge, for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | 64 | Conditioned interrupt lines, shared by all banks |
| bus_addr_i | input | 10 | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after `bus_re_i` |
| irq_o | output | 3 | Combined interrupt output, one bit per bank |

## Verification
The assertions assume that `irq_src_i` comes from a synchronous conditioning stage and changes only between clock edges. They also assume that the read strobe is a single-cycle pulse per access, so each valid response can be matched to one request. The bench drives every input on the falling clock edge and issues each register access as a one-cycle strobe with an idle cycle after it. It never asserts the read and write strobes together, so the ordering of a read against a write in the same cycle is never relied on.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int WORD_W       = 32;
  localparam int NUM_WORDS    = 2;
  localparam int NUM_BANKS    = 3;
  localparam int ADDR_W       = 10;
  localparam int GROUP_STRIDE = 'h18;
  // address page (addr[9:8]) of each bank; page 2 stays unmapped
  localparam int BANK_PAGE [NUM_BANKS] = '{0, 1, 3};

  typedef enum logic [2:0] {
    REG_STAT     = 3'd0,
    REG_RAW      = 3'd1,
    REG_EN_SET   = 3'd2,
    REG_EN_CLR   = 3'd3,
    REG_SOFT_SET = 3'd4,
    REG_SOFT_CLR = 3'd5,
    REG_NONE     = 3'd7
  } reg_kind_e;
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = irq_bank_pkg::ADDR_W,
  parameter int NB     = irq_bank_pkg::NUM_BANKS,
  parameter int NW     = irq_bank_pkg::NUM_WORDS
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NB-1:0]     bank_hit_o,
  output logic [NW-1:0]     word_sel_o,
  output reg_kind_e         kind_o
);
  localparam int PAGE_W = ADDR_W - 8;

  logic [PAGE_W-1:0] page;
  logic [7:0]        offs;

  assign page = addr_i[ADDR_W-1:8];
  assign offs = addr_i[7:0];

  always_comb begin
    bank_hit_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (int'(page) == BANK_PAGE[b]) bank_hit_o[b] = 1'b1;
    end
  end

  always_comb begin
    word_sel_o = '0;
    kind_o     = REG_NONE;
    if (offs[1:0] == 2'b00) begin
      for (int w = 0; w < NW; w++) begin
        if (int'(offs) >= w * GROUP_STRIDE && int'(offs) < (w + 1) * GROUP_STRIDE) begin
          word_sel_o[w] = 1'b1;
          kind_o        = reg_kind_e'(3'((int'(offs) - w * GROUP_STRIDE) >> 2));
        end
      end
    end
  end
endmodule

// File: rtl/irq_word_regs.sv
module irq_word_regs
  import irq_bank_pkg::*;
#(
  parameter int W = irq_bank_pkg::WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         wr_i,
  input  reg_kind_e    kind_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] en_q, soft_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      soft_q <= '0;
    end else if (wr_i) begin
      unique case (kind_i)
        REG_EN_SET:   en_q   <= en_q | wdata_i;
        REG_EN_CLR:   en_q   <= en_q & ~wdata_i;
        REG_SOFT_SET: soft_q <= soft_q | wdata_i;
        REG_SOFT_CLR: soft_q <= soft_q & ~wdata_i;
        default: ;  // status offsets are read-only
      endcase
    end
  end

  assign raw_o  = src_i | soft_q;
  assign stat_o = raw_o & en_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int W  = irq_bank_pkg::WORD_W,
  parameter int NW = irq_bank_pkg::NUM_WORDS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W*NW-1:0] src_i,
  input  logic            wr_i,
  input  logic [NW-1:0]   word_sel_i,
  input  reg_kind_e       kind_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W*NW-1:0] raw_o,
  output logic [W*NW-1:0] stat_o,
  output logic [W-1:0]    rd_word_o,
  output logic            irq_o
);
  logic [NW-1:0][W-1:0] raw_w, stat_w;

  for (genvar w = 0; w < NW; w++) begin : g_word
    irq_word_regs #(.W(W)) u_word (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_i[w*W +: W]),
      .wr_i    (wr_i & word_sel_i[w]),
      .kind_i  (kind_i),
      .wdata_i (wdata_i),
      .raw_o   (raw_w[w]),
      .stat_o  (stat_w[w])
    );
  end

  assign raw_o  = raw_w;
  assign stat_o = stat_w;

  // set/clear ports are write-only and read back as zero
  always_comb begin
    rd_word_o = '0;
    for (int w = 0; w < NW; w++) begin
      if (word_sel_i[w]) begin
        if (kind_i == REG_STAT)     rd_word_o = stat_w[w];
        else if (kind_i == REG_RAW) rd_word_o = raw_w[w];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |stat_w;
  end
endmodule

// File: rtl/irq_mask_bank_top.sv
module irq_mask_bank_top
  import irq_bank_pkg::*;
#(
  parameter int W      = irq_bank_pkg::WORD_W,
  parameter int NW     = irq_bank_pkg::NUM_WORDS,
  parameter int NB     = irq_bank_pkg::NUM_BANKS,
  parameter int ADDR_W = irq_bank_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W*NW-1:0]   irq_src_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [W-1:0]      bus_wdata_i,
  input  logic              bus_re_i,
  output logic [W-1:0]      bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic [NB-1:0]     irq_o
);
  localparam int LINES = W * NW;

  logic [NB-1:0]             bank_hit;
  logic [NW-1:0]             word_sel;
  reg_kind_e                 kind;
  logic [NB-1:0][LINES-1:0]  bank_raw, bank_stat;
  logic [NB-1:0][W-1:0]      bank_rd;
  logic [W-1:0]              rd_mux;

  irq_bank_decode #(.ADDR_W(ADDR_W), .NB(NB), .NW(NW)) u_dec (
    .addr_i     (bus_addr_i),
    .bank_hit_o (bank_hit),
    .word_sel_o (word_sel),
    .kind_o     (kind)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    irq_bank #(.W(W), .NW(NW)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (irq_src_i),
      .wr_i       (bus_we_i & bank_hit[b]),
      .word_sel_i (word_sel),
      .kind_i     (kind),
      .wdata_i    (bus_wdata_i),
      .raw_o      (bank_raw[b]),
      .stat_o     (bank_stat[b]),
      .rd_word_o  (bank_rd[b]),
      .irq_o      (irq_o[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NB; b++) begin
      if (bank_hit[b]) rd_mux = rd_mux | bank_rd[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o  <= '0;
      bus_rvalid_o <= 1'b0;
    end else begin
      bus_rvalid_o <= bus_re_i;
      bus_rdata_o  <= bus_re_i ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/irq_mask_bank_chk.sv
module irq_mask_bank_chk #(
  parameter int LINES  = 64,
  parameter int NB     = 3,
  parameter int W      = 32,
  parameter int ADDR_W = 10,
  parameter int SPAN   = 'h30
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [LINES-1:0]         irq_src_i,
  input logic [ADDR_W-1:0]        bus_addr_i,
  input logic                     bus_re_i,
  input logic [W-1:0]             bus_rdata_o,
  input logic                     bus_rvalid_o,
  input logic [NB-1:0]            irq_o,
  input logic [NB-1:0][LINES-1:0] bank_raw,
  input logic [NB-1:0][LINES-1:0] bank_stat
);
  logic unmapped_rd;
  assign unmapped_rd = bus_re_i && (bus_addr_i[9:8] == 2'd2 ||
                                    int'(bus_addr_i[7:0]) >= SPAN ||
                                    bus_addr_i[1:0] != 2'b00);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (irq_o == '0 && !bus_rvalid_o && bus_rdata_o == '0)
        else $error("reset outputs not idle");
    end
  end

  a_r12_rvalid_follows_re: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_re_i |=> bus_rvalid_o);
  a_r12_rvalid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_re_i |=> !bus_rvalid_o);
  a_r11_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_rd |=> bus_rdata_o == '0);

  for (genvar b = 0; b < NB; b++) begin : g_b
    a_r2_raw_covers_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_src_i & ~bank_raw[b]) == '0);
    a_r3_stat_within_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_stat[b] & ~bank_raw[b]) == '0);
    a_r9_irq_tracks_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[b] == (|$past(bank_stat[b])));
  end
endmodule

bind irq_mask_bank_top irq_mask_bank_chk #(
  .LINES(W * NW), .NB(NB), .W(W), .ADDR_W(ADDR_W), .SPAN(NW * 'h18)
) u_chk (.*);

// File: tb/irq_mask_bank_top_test.sv
module irq_mask_bank_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic [9:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [2:0]  irq;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] m_en[3], m_soft[3];

  always #5 clk = ~clk;

  irq_mask_bank_top uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_re_i(re),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .irq_o(irq)
  );

  function automatic int bank_of(logic [9:0] a);
    case (a[9:8])
      2'd0: return 0;
      2'd1: return 1;
      2'd3: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(logic [9:0] a);
    int b = bank_of(a);
    int o = int'(a[7:0]);
    int h;
    logic [63:0] raw, msk;
    if (b < 0 || a[1:0] != 2'b00 || o >= 'h30) return '0;
    h = (o >= 'h18) ? 1 : 0;
    o = o - h * 'h18;
    raw = src | m_soft[b];
    msk = raw & m_en[b];
    if (o == 0) return h ? msk[63:32] : msk[31:0];
    if (o == 4) return h ? raw[63:32] : raw[31:0];
    return '0;
  endfunction

  function automatic void model_wr(logic [9:0] a, logic [31:0] d);
    int b = bank_of(a);
    int o = int'(a[7:0]);
    int h;
    logic [63:0] m;
    if (b < 0 || a[1:0] != 2'b00 || o >= 'h30) return;
    h = (o >= 'h18) ? 1 : 0;
    o = o - h * 'h18;
    m = h ? {d, 32'h0} : {32'h0, d};
    case (o)
      8:  m_en[b]   = m_en[b] | m;
      12: m_en[b]   = m_en[b] & ~m;
      16: m_soft[b] = m_soft[b] | m;
      20: m_soft[b] = m_soft[b] & ~m;
      default: ;
    endcase
  endfunction

  function automatic logic [2:0] exp_irq();
    logic [2:0] r;
    for (int b = 0; b < 3; b++) r[b] = |((src | m_soft[b]) & m_en[b]);
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic bus_read(logic [9:0] a, string tag);
    @(negedge clk);
    exp_q.push_back(exp_rd(a));
    tag_q.push_back(tag);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic check_irq(string tag);
    @(negedge clk);
    check(tag, {61'h0, irq}, {61'h0, exp_irq()});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check("R12 unexpected rvalid", 64'(rdata), 64'hx);
      else check(tag_q.pop_front(), 64'(rdata), 64'(exp_q.pop_front()));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 3; b++) begin m_en[b] = '0; m_soft[b] = '0; end
    repeat (3) @(negedge clk);
    check("R1 reset irq", {61'h0, irq}, 64'h0);
    check("R1 reset rvalid", {63'h0, rvalid}, 64'h0);
    check("R1 reset rdata", 64'(rdata), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {61'h0, irq}, 64'h0);
    bus_read(10'h000, "R1 masked low zero");
    bus_read(10'h118, "R1 masked high zero");

    src = 64'h0000_0001_8000_0010;
    bus_read(10'h004, "R2 raw low");
    bus_read(10'h01C, "R2 raw high");
    bus_read(10'h000, "R3 masked with no enables");
    check_irq("R9 no enables");

    bus_write(10'h008, 32'h0000_0010);
    bus_read(10'h000, "R4 enable bit4");
    check_irq("R8 only bank0 fires");
    bus_write(10'h008, 32'hFFFF_0000);
    bus_read(10'h000, "R4 set keeps other bits");
    bus_write(10'h00C, 32'h0000_0010);
    bus_read(10'h000, "R5 clear one bit");
    bus_write(10'h020, 32'h0000_0001);
    bus_read(10'h018, "R7 high group masked");
    bus_read(10'h000, "R7 low unchanged by high write");

    bus_write(10'h000, 32'hFFFF_FFFF);
    bus_write(10'h004, 32'hFFFF_FFFF);
    bus_write(10'h01C, 32'hFFFF_FFFF);
    bus_read(10'h000, "R10 status write ignored");
    bus_read(10'h01C, "R10 raw write ignored");

    bus_write(10'h00C, 32'hFFFF_FFFF);
    bus_read(10'h000, "R5 all-ones clear low");
    bus_read(10'h018, "R5 high still enabled");
    bus_write(10'h024, 32'hFFFF_FFFF);
    bus_read(10'h018, "R5 all-ones clear high");
    check_irq("R9 irq drops");

    bus_write(10'h110, 32'h0000_0F00);
    bus_read(10'h104, "R6 soft set raw");
    bus_read(10'h004, "R8 bank0 raw untouched");
    bus_write(10'h108, 32'h0000_0100);
    bus_read(10'h100, "R6 soft line masked");
    check_irq("R8 bank1 fires alone");
    bus_write(10'h114, 32'h0000_0300);
    bus_read(10'h104, "R6 soft clear raw");
    check_irq("R9 bank1 drops");

    bus_write(10'h320, 32'hFFFF_FFFF);
    bus_read(10'h318, "R8 bank2 high masked");
    check_irq("R8 bank2 fires");
    @(negedge clk);
    src = '0;
    check_irq("R9 one cycle after source drop");

    bus_write(10'h208, 32'hFFFF_FFFF);
    bus_write(10'h038, 32'hFFFF_FFFF);
    bus_write(10'h009, 32'hFFFF_FFFF);
    src = 64'hFFFF_FFFF_FFFF_FFFF;
    check_irq("R11 unmapped writes no effect");
    bus_read(10'h200, "R11 page 2 zero");
    bus_read(10'h030, "R11 past groups zero");
    bus_read(10'h305, "R11 unaligned zero");
    bus_read(10'h308, "R11 write-only port zero");
    bus_read(10'h000, "R11 bank0 masked still zero");

    repeat (3) @(negedge clk);
    check("R12 rvalid idle", {63'h0, rvalid}, 64'h0);
    check("R12 scoreboard drained", 64'(exp_q.size()), 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule